// File: doc/BRIEF.md
# Discrete Sensor Serial Register Front End

This block is the serial-port register front end of a 32-input discrete threshold sensor. An SPI master (mode 0, chip select active low) talks to it in framed transfers. The first byte of each frame is a command carrying a direction flag and a 7-bit register address. The data bytes that follow travel most significant byte first. The block samples the serial pins with the system clock, assembles bytes, commits writes, and shifts read data back out.

The block holds the configuration the sensor core uses: a two-bit control register (test-mode enable and software reset), a per-group sensing-mode register in which each bit covers eight consecutive channels, and two 16-bit threshold codes, one per sensing mode. Each code stores the hysteresis in its upper byte and the sum of the two limits in its lower byte. The live channel levels are captured into a status snapshot every clock. Software reads the snapshot either one 8-channel group at a time or as one 32-bit word.

Writing a threshold code whose hysteresis is odd puts the block into a locked state. In that state the status snapshot stops following the inputs. Only a hardware reset or a software reset leaves the locked state. While the software-reset bit is set, all other state is held cleared.

Top module: `dsense_spi_regs`

## Requirements
- R1: A frame's first byte is a command. Bit 7 = 1 selects a read and bit 7 = 0 selects a write; bits 6:0 are the register address. Bytes that follow a read command never change any register.
- R2: Multi-byte registers move most significant byte first in both directions. A 16-bit write is committed only when its second (low) data byte completes. The register then holds {first byte, second byte}.
- R3: SPI mode 0 is used. MOSI is sampled on rising SCLK and MISO changes after falling SCLK. The MSB of read data is on MISO before the first data-bit rising edge. MISO is 0 while chip select is high and during the command byte.
- R4: The control register is at address 0x02. Bit 0 drives `test_mode` and bit 1 drives `soft_reset`. It reads back as {6'b0, bit1, bit0}, and written bits 7:2 are dropped.
- R5: The sensing-mode register is at address 0x04 and uses bits 3:0. Bit n set selects supply-open sensing (1) for channels 8n..8n+7, and clear selects ground-open (0). `group_supply` shows the four bits and `chan_supply[c]` equals bit c/8. Upper bits read as zero.
- R6: While control bit 1 is set, the sensing mode, both threshold codes, the lock flag and the status snapshot are held at zero, and writes to them are dropped. Writing the control register back to zero leaves them in their reset values.
- R7: The ground-open threshold code is at 0x3A and the supply-open code is at 0x3C. Each is 16 bits: upper byte = high limit minus low limit, lower byte = high limit plus low limit. Each is visible on `gnd_thr` / `sup_thr` and reads back unchanged.
- R8: Writing a threshold code with an odd upper byte stores the code and sets `locked`. While locked, the status snapshot holds its value whatever the channel inputs do. Only `rst_n` low or control bit 1 clears `locked`.
- R9: Status reads at 0x10, 0x12, 0x14 and 0x16 return channels 7..0, 15..8, 23..16 and 31..24, with bit k of the byte being the lowest channel of that group plus k. A read at 0x78 returns all 32 channels, channel 31 first.
- R10: Raising chip select ends the frame at any bit. It discards any partly shifted byte and any uncommitted 16-bit write, and the next frame starts from its command byte.
- R11: Reads of any address not listed in R4, R5, R7 or R9 return zero. Writes to such addresses, or to the status addresses, change nothing.
- R12: After `rst_n` every register, every output and MISO is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| chan_level | input | 32 | Live comparator result of each channel |
| test_mode | output | 1 | Control bit 0 |
| soft_reset | output | 1 | Control bit 1, holds the rest of the block cleared |
| group_supply | output | 4 | Sensing mode per eight-channel group |
| chan_supply | output | 32 | Sensing mode expanded to each channel |
| gnd_thr | output | 16 | Ground-open threshold code {hysteresis, limit sum} |
| sup_thr | output | 16 | Supply-open threshold code {hysteresis, limit sum} |
| locked | output | 1 | Set after an odd-hysteresis threshold write |

## Verification
The hardest state to reach from the pins is a frozen status snapshot. It appears only after a complete, well-formed 16-bit threshold write with an odd upper byte, and it is visible only when the channel inputs change afterwards and a later read still returns the old levels. The bench drives a known pattern, locks the block with such a write, changes the inputs, and reads the 32-bit view. It then leaves the locked state once through the software-reset bit and once through `rst_n`. Frames cut short after a high byte and in the middle of a byte show that aborted writes are dropped and that the byte counter restarts.

// File: rtl/dsense_pkg.sv
package dsense_pkg;

  // Register addresses (the bus master depends on these values)
  localparam logic [6:0] ADDR_CTRL     = 7'h02;
  localparam logic [6:0] ADDR_SENSE    = 7'h04;
  localparam logic [6:0] ADDR_GRP_BASE = 7'h10;
  localparam logic [6:0] ADDR_THR_GND  = 7'h3A;
  localparam logic [6:0] ADDR_THR_SUP  = 7'h3C;
  localparam logic [6:0] ADDR_ALL      = 7'h78;

  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_BYTE = 2'd1,
    WK_PAIR = 2'd2
  } wr_kind_e;

  typedef struct packed {
    logic       rd;
    logic [6:0] addr;
  } cmd_t;

  // Width class of a writable address
  function automatic wr_kind_e wr_kind(input logic [6:0] a);
    case (a)
      ADDR_CTRL, ADDR_SENSE:     return WK_BYTE;
      ADDR_THR_GND, ADDR_THR_SUP: return WK_PAIR;
      default:                   return WK_NONE;
    endcase
  endfunction

  // Group status address: base plus twice the group number
  function automatic logic is_group_addr(input logic [6:0] a, input int ngrp);
    int off;
    off = int'(a) - int'(ADDR_GRP_BASE);
    return (off >= 0) && (off % 2 == 0) && (off / 2 < ngrp);
  endfunction

  function automatic int group_of(input logic [6:0] a);
    return (int'(a) - int'(ADDR_GRP_BASE)) / 2;
  endfunction

  // Hysteresis lives in the upper byte; odd means lock
  function automatic logic hyst_odd(input logic [15:0] code);
    return code[8];
  endfunction

  function automatic logic [7:0] group_byte(input logic [WORD_W-1:0] s, input int g);
    return s[g*BYTE_W +: BYTE_W];
  endfunction

endpackage

// File: rtl/dsense_sync.sv
module dsense_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rst_val_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= rst_val_i;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= rst_val_i;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dsense_spi_shift.sv
module dsense_spi_shift
  import dsense_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  output logic              miso_o,
  output logic              byte_valid_o,
  output logic [2:0]        byte_num_o,
  output logic [7:0]        byte_o
);

  logic [2:0] raw, synced;
  logic       sclk_s, cs_n_s, mosi_s, sclk_d;
  logic       rise, fall;

  assign raw = {sclk_i, cs_n_i, mosi_i};

  dsense_sync #(.W(3), .STAGES(SYNC)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_i       (raw),
    .rst_val_i (3'b010),
    .q_o       (synced)
  );

  assign sclk_s = synced[2];
  assign cs_n_s = synced[1];
  assign mosi_s = synced[0];

  // Edge events, only meaningful inside a frame
  assign rise = sclk_s & ~sclk_d & ~cs_n_s;
  assign fall = ~sclk_s & sclk_d & ~cs_n_s;

  logic [2:0]        bit_cnt;
  logic [2:0]        byte_idx;
  logic [6:0]        rx_sr;
  logic [WORD_W-1:0] tx_q;
  logic              shift_pend;
  logic              bv_q;
  logic [2:0]        bn_q;
  logic [7:0]        byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      byte_idx   <= '0;
      rx_sr      <= '0;
      tx_q       <= '0;
      shift_pend <= 1'b0;
      bv_q       <= 1'b0;
      bn_q       <= '0;
      byte_q     <= '0;
    end else if (cs_n_s) begin
      bit_cnt    <= '0;
      byte_idx   <= '0;
      rx_sr      <= '0;
      tx_q       <= '0;
      shift_pend <= 1'b0;
      bv_q       <= 1'b0;
    end else begin
      bv_q <= 1'b0;
      if (rise) begin
        rx_sr   <= {rx_sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (byte_idx != 3'd0) shift_pend <= 1'b1;
        if (bit_cnt == 3'd7) begin
          bv_q   <= 1'b1;
          byte_q <= {rx_sr, mosi_s};
          bn_q   <= byte_idx;
          if (byte_idx != 3'd7) byte_idx <= byte_idx + 3'd1;
        end
      end
      if (load_i) begin
        tx_q       <= load_word_i;
        shift_pend <= 1'b0;
      end else if (fall && shift_pend) begin
        tx_q       <= {tx_q[WORD_W-2:0], 1'b0};
        shift_pend <= 1'b0;
      end
    end
  end

  assign miso_o       = tx_q[WORD_W-1] & ~cs_n_s;
  assign byte_valid_o = bv_q;
  assign byte_num_o   = bn_q;
  assign byte_o       = byte_q;

  a_r10_abort_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (bit_cnt == 3'd0 && byte_idx == 3'd0 && !bv_q));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (tx_q == '0));

  a_r2_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |=> !bv_q);

  a_r3_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !load_i) |=> ($stable(tx_q) || tx_q == '0));

endmodule

// File: rtl/dsense_regs.sv
module dsense_regs
  import dsense_pkg::*;
#(
  parameter int NCH = 32,
  parameter int GRP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid_i,
  input  logic [2:0]        byte_num_i,
  input  logic [7:0]        byte_i,
  input  logic [NCH-1:0]    chan_level_i,
  input  logic [6:0]        rd_addr_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              test_mode_o,
  output logic              soft_reset_o,
  output logic [NCH/GRP-1:0] group_supply_o,
  output logic [NCH-1:0]    chan_supply_o,
  output logic [15:0]       gnd_thr_o,
  output logic [15:0]       sup_thr_o,
  output logic              locked_o
);

  localparam int NGRP = NCH / GRP;

  cmd_t             cmd_q;
  logic [1:0]       ctrl_q;
  logic [NGRP-1:0]  sense_q;
  logic [7:0]       hi_stage;
  logic [15:0]      thr_g_q, thr_s_q;
  logic             lock_q;
  logic [NCH-1:0]   status_q;

  // Named write events
  logic        cmd_ev, wr_byte_ev, wr_pair_ev, odd_write, sreset;
  logic [15:0] pair_word;

  assign sreset     = ctrl_q[1];
  assign cmd_ev     = byte_valid_i && (byte_num_i == 3'd0);
  assign wr_byte_ev = byte_valid_i && (byte_num_i == 3'd1) && !cmd_q.rd;
  assign wr_pair_ev = byte_valid_i && (byte_num_i == 3'd2) && !cmd_q.rd &&
                      (wr_kind(cmd_q.addr) == WK_PAIR);
  assign pair_word  = {hi_stage, byte_i};
  assign odd_write  = wr_pair_ev && hyst_odd(pair_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (cmd_ev) cmd_q <= cmd_t'(byte_i);
      if (wr_byte_ev && cmd_q.addr == ADDR_CTRL) ctrl_q <= byte_i[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q  <= '0;
      hi_stage <= '0;
      thr_g_q  <= '0;
      thr_s_q  <= '0;
      lock_q   <= 1'b0;
      status_q <= '0;
    end else if (sreset) begin
      sense_q  <= '0;
      hi_stage <= '0;
      thr_g_q  <= '0;
      thr_s_q  <= '0;
      lock_q   <= 1'b0;
      status_q <= '0;
    end else begin
      if (!lock_q) status_q <= chan_level_i;
      if (wr_byte_ev) begin
        hi_stage <= byte_i;
        if (cmd_q.addr == ADDR_SENSE) sense_q <= byte_i[NGRP-1:0];
      end
      if (wr_pair_ev) begin
        if (cmd_q.addr == ADDR_THR_GND) thr_g_q <= pair_word;
        else                            thr_s_q <= pair_word;
        if (odd_write) lock_q <= 1'b1;
      end
    end
  end

  // Read view, left aligned so the shifter always starts at its MSB
  logic [WORD_W-1:0] stat32;
  always_comb begin
    stat32 = '0;
    stat32[NCH-1:0] = status_q;
  end

  always_comb begin
    rd_word_o = '0;
    if (is_group_addr(rd_addr_i, NGRP)) begin
      rd_word_o[WORD_W-1 -: 8] = group_byte(stat32, group_of(rd_addr_i));
    end else begin
      case (rd_addr_i)
        ADDR_CTRL:    rd_word_o[WORD_W-1 -: 8] = {6'b0, ctrl_q};
        ADDR_SENSE:   rd_word_o[WORD_W-1 -: 8] = 8'(sense_q);
        ADDR_THR_GND: rd_word_o[WORD_W-1 -: 16] = thr_g_q;
        ADDR_THR_SUP: rd_word_o[WORD_W-1 -: 16] = thr_s_q;
        ADDR_ALL:     rd_word_o = stat32;
        default:      rd_word_o = '0;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_fan
      assign chan_supply_o[g*GRP +: GRP] = {GRP{sense_q[g]}};
    end
  endgenerate

  assign test_mode_o    = ctrl_q[0];
  assign soft_reset_o   = ctrl_q[1];
  assign group_supply_o = sense_q;
  assign gnd_thr_o      = thr_g_q;
  assign sup_thr_o      = thr_s_q;
  assign locked_o       = lock_q;

  a_r1_cmd_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ev |=> (cmd_q == $past(byte_i)));

  a_r4_ctrl_only_written: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_byte_ev && cmd_q.addr == ADDR_CTRL) |=> $stable(ctrl_q));

  a_r6_sreset_holds: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (sense_q == '0 && thr_g_q == '0 && thr_s_q == '0 &&
                !lock_q && status_q == '0));

  a_r8_odd_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_write && !sreset) |=> lock_q);

  a_r8_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !sreset) |=> $stable(status_q));

endmodule

// File: rtl/dsense_spi_regs.sv
module dsense_spi_regs
  import dsense_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int GRP  = 8,
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  input  logic [31:0] chan_level,
  output logic        test_mode,
  output logic        soft_reset,
  output logic [3:0]  group_supply,
  output logic [31:0] chan_supply,
  output logic [15:0] gnd_thr,
  output logic [15:0] sup_thr,
  output logic        locked
);

  logic              byte_valid;
  logic [2:0]        byte_num;
  logic [7:0]        rx_byte;
  logic              rd_load;
  logic [WORD_W-1:0] rd_word;

  // A completed read command loads the reply at once
  assign rd_load = byte_valid && (byte_num == 3'd0) && rx_byte[7];

  dsense_spi_shift #(.SYNC(SYNC)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_i       (spi_sclk),
    .cs_n_i       (spi_cs_n),
    .mosi_i       (spi_mosi),
    .load_i       (rd_load),
    .load_word_i  (rd_word),
    .miso_o       (spi_miso),
    .byte_valid_o (byte_valid),
    .byte_num_o   (byte_num),
    .byte_o       (rx_byte)
  );

  dsense_regs #(.NCH(NCH), .GRP(GRP)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .byte_valid_i   (byte_valid),
    .byte_num_i     (byte_num),
    .byte_i         (rx_byte),
    .chan_level_i   (chan_level),
    .rd_addr_i      (rx_byte[6:0]),
    .rd_word_o      (rd_word),
    .test_mode_o    (test_mode),
    .soft_reset_o   (soft_reset),
    .group_supply_o (group_supply),
    .chan_supply_o  (chan_supply),
    .gnd_thr_o      (gnd_thr),
    .sup_thr_o      (sup_thr),
    .locked_o       (locked)
  );

  a_r12_idle_miso: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_cs_n) && spi_cs_n) |-> !spi_miso);

endmodule

// File: tb/dsense_spi_regs_test.sv
module dsense_spi_regs_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF       = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic [31:0] chan_level = '0;
  logic        test_mode, soft_reset, locked;
  logic [3:0]  group_supply;
  logic [31:0] chan_supply;
  logic [15:0] gnd_thr, sup_thr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsense_spi_regs uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .chan_level(chan_level),
    .test_mode(test_mode), .soft_reset(soft_reset), .group_supply(group_supply),
    .chan_supply(chan_supply), .gnd_thr(gnd_thr), .sup_thr(sup_thr), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [39:0] tx, input int nbits,
                      output logic [31:0] rx, output logic cmd_seen);
    rx = '0;
    cmd_seen = 1'b0;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[39-i];
      repeat (HALF) @(negedge clk);
      if (i < 8) cmd_seen = cmd_seen | spi_miso;
      else       rx = {rx[30:0], spi_miso};
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr8(input logic [6:0] a, input logic [7:0] v);
    logic [31:0] r; logic c;
    xfer({1'b0, a, v, 24'h0}, 16, r, c);
  endtask

  task automatic wr16(input logic [6:0] a, input logic [15:0] v);
    logic [31:0] r; logic c;
    xfer({1'b0, a, v, 16'h0}, 24, r, c);
  endtask

  task automatic rd(input logic [6:0] a, input int nbytes, output logic [31:0] v);
    logic c;
    xfer({1'b1, a, 32'h0}, 8 + 8*nbytes, v, c);
  endtask

  function automatic bit mapped(input int a);
    return a == 'h02 || a == 'h04 || a == 'h3A || a == 'h3C || a == 'h10 ||
           a == 'h12 || a == 'h14 || a == 'h16 || a == 'h78;
  endfunction

  function automatic logic [15:0] thr_code(input int lo, input int hi);
    return 16'(((hi - lo) * 256) + (hi + lo));
  endfunction

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp32;
    logic        cseen;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk({test_mode, soft_reset, group_supply, locked} == '0 && chan_supply == '0,
        "R12 ctrl/sense outputs", {test_mode, soft_reset, group_supply, locked}, 0);
    chk(gnd_thr == 0 && sup_thr == 0, "R12 thresholds", {gnd_thr, sup_thr}, 0);
    chk(spi_miso == 1'b0, "R12 miso idle", spi_miso, 0);

    // R4 control register
    wr8(7'h02, 8'hFD);
    chk(test_mode == 1'b1 && soft_reset == 1'b0, "R4 test bit out",
        {test_mode, soft_reset}, 2'b10);
    rd(7'h02, 1, v);
    chk(v[7:0] == 8'h01, "R4 ctrl readback upper dropped", v[7:0], 8'h01);
    wr8(7'h02, 8'h00);
    chk(test_mode == 1'b0, "R4 test bit clear", test_mode, 0);

    // R5 sensing-mode sweep
    for (int m = 0; m < 16; m++) begin
      logic [31:0] fan;
      wr8(7'h04, 8'(m) | 8'hF0);
      for (int c = 0; c < 32; c++) fan[c] = m[c/8];
      chk(group_supply == 4'(m), "R5 group mode", group_supply, m);
      chk(chan_supply == fan, "R5 channel fan-out", chan_supply, fan);
      rd(7'h04, 1, v);
      chk(v[7:0] == 8'(m), "R5 readback", v[7:0], m);
    end

    // R1 read command with trailing data changes nothing
    xfer({1'b1, 7'h04, 8'hA0, 24'h0}, 16, v, cseen);
    chk(group_supply == 4'hF, "R1 read leaves sense", group_supply, 4'hF);
    xfer({1'b1, 7'h3A, 16'h0307, 16'h0}, 24, v, cseen);
    chk(gnd_thr == 0 && !locked, "R1 read leaves threshold", {locked, gnd_thr}, 0);

    // R7 / R2 threshold codes, MSB-first
    for (int lo = 2; lo <= 18; lo += 4) begin
      for (int h = 2; h <= 6; h += 2) begin
        logic [15:0] cg, cs;
        cg = thr_code(lo, lo + h);
        cs = thr_code(lo + 1, lo + 1 + h);
        wr16(7'h3A, cg);
        wr16(7'h3C, cs);
        chk(gnd_thr == cg, "R7 gnd code out", gnd_thr, cg);
        chk(sup_thr == cs, "R7 sup code out", sup_thr, cs);
        rd(7'h3A, 2, v);
        chk(v[15:0] == cg, "R2 gnd readback", v[15:0], cg);
        rd(7'h3C, 2, v);
        chk(v[15:0] == cs, "R2 sup readback", v[15:0], cs);
        chk(!locked, "R8 even hysteresis no lock", locked, 0);
      end
    end

    // R9 / R3 status walk
    for (int k = 0; k < 32; k++) begin
      chan_level = 32'h1 << k;
      repeat (4) @(negedge clk);
      xfer({1'b1, 7'h78, 32'h0}, 40, v, cseen);
      chk(v == chan_level, "R9 word view", v, chan_level);
      chk(cseen == 1'b0, "R3 miso low in command", cseen, 0);
    end
    chan_level = 32'hC3A5_5A3C;
    repeat (4) @(negedge clk);
    for (int g = 0; g < 4; g++) begin
      rd(7'(8'h10 + 2*g), 1, v);
      exp32 = (chan_level >> (8*g)) & 32'hFF;
      chk(v == exp32, "R9 group view", v, exp32);
    end

    // R11 unmapped reads, ignored writes
    for (int a = 0; a < 128; a++) begin
      if (!mapped(a)) begin
        rd(7'(a), 1, v);
        chk(v == 0, "R11 unmapped read zero", v, 0);
        wr8(7'(a), 8'hFF);
      end
    end
    wr8(7'h10, 8'h00);
    xfer({1'b0, 7'h78, 32'h0}, 40, v, cseen);
    chk(group_supply == 4'hF && !test_mode && !soft_reset, "R11 writes ignored",
        {test_mode, soft_reset, group_supply}, 6'h0F);
    chk(gnd_thr == thr_code(18, 24) && sup_thr == thr_code(19, 25), "R11 thresholds kept",
        {gnd_thr, sup_thr}, {thr_code(18, 24), thr_code(19, 25)});
    rd(7'h78, 4, v);
    chk(v == chan_level, "R11 status unaffected", v, chan_level);

    // R10 abort after the high byte and mid-byte
    wr16(7'h3A, 16'h0206);
    xfer({1'b0, 7'h3A, 8'h04, 24'h0}, 16, v, cseen);
    chk(gnd_thr == 16'h0206, "R10 partial pair dropped", gnd_thr, 16'h0206);
    xfer({1'b0, 7'h3A, 32'h0}, 5, v, cseen);
    wr16(7'h3A, 16'h040A);
    chk(gnd_thr == 16'h040A, "R10 restart after cut", gnd_thr, 16'h040A);

    // R8 lock freezes status, software reset clears
    chan_level = 32'hA5A5_0F0F;
    repeat (4) @(negedge clk);
    wr16(7'h3A, 16'h0307);
    chk(locked == 1'b1, "R8 odd hysteresis locks", locked, 1);
    chk(gnd_thr == 16'h0307, "R8 odd code stored", gnd_thr, 16'h0307);
    chan_level = 32'h1234_5678;
    repeat (4) @(negedge clk);
    rd(7'h78, 4, v);
    chk(v == 32'hA5A5_0F0F, "R8 status frozen", v, 32'hA5A5_0F0F);

    // R6 soft reset holds state cleared
    wr8(7'h02, 8'h02);
    chk(soft_reset == 1'b1 && !locked, "R6 soft reset clears lock", {soft_reset, locked}, 2'b10);
    chk(gnd_thr == 0 && sup_thr == 0 && group_supply == 0, "R6 config cleared",
        {gnd_thr, sup_thr}, 0);
    wr8(7'h04, 8'h0F);
    wr16(7'h3C, 16'h0206);
    chk(group_supply == 0 && sup_thr == 0, "R6 writes dropped in reset",
        {group_supply, sup_thr}, 0);
    rd(7'h78, 4, v);
    chk(v == 0, "R6 status held zero", v, 0);
    wr8(7'h02, 8'h00);
    chk(!soft_reset && group_supply == 0 && gnd_thr == 0, "R6 release keeps reset values",
        {soft_reset, group_supply, gnd_thr}, 0);
    rd(7'h78, 4, v);
    chk(v == 32'h1234_5678, "R8 status follows after soft reset", v, 32'h1234_5678);

    // R8 / R12 hardware reset clears lock
    wr16(7'h3C, 16'h0105);
    chk(locked == 1'b1, "R8 lock via supply code", locked, 1);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!locked && sup_thr == 0, "R12 hw reset clears lock", {locked, sup_thr}, 0);
    chan_level = 32'h0000_FFFF;
    repeat (4) @(negedge clk);
    rd(7'h78, 4, v);
    chk(v == 32'h0000_FFFF, "R8 status live after hw reset", v, 32'h0000_FFFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule